// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit single-precision binary floating-point operands and produces a 32-bit single-precision product. Each word holds the sign in bit 31, an 8-bit exponent biased by 127 in bits 30:23, and a 23-bit fraction in bits 22:0. A hidden leading one sits above the fraction, so each significand is 24 bits wide.

Operands must be normalized, meaning the exponent field lies strictly between 0 and 255. Denormals, NaN and infinity on the inputs are not handled, and the only rounding the block performs is truncation. An input strobe marks a valid operand pair. A new pair may arrive on every cycle, and the result appears after a fixed two-cycle latency with its own strobe. Overflow and underflow flags report a result exponent that cannot be encoded. In those cases the product is replaced by signed infinity or signed zero.

Top module: `fmul_sp`

## Requirements
- R1: The product sign (bit 31) equals the XOR of the two operand sign bits. This holds for normal, overflowed and underflowed results.
- R2: When bit 47 of the 48-bit significand product is clear, the result exponent is Ea + Eb - 127. The result fraction is product bits 45:23.
- R3: When bit 47 of the significand product is set, the product is shifted right by one. The result exponent is then Ea + Eb - 126, and the fraction is product bits 46:24.
- R4: Significand bits below the kept fraction are discarded without rounding. Two all-ones fractions, for example, give a truncated fraction and not a rounded-up one.
- R5: If the final exponent is 255 or more, `ovf` is 1 and the product is signed infinity: exponent field 8'hFF and fraction 0.
- R6: If the final exponent is 0 or less, `unf` is 1 and the product is signed zero: bits 30:0 all 0.
- R7: `out_valid` equals `in_valid` from exactly two clock edges earlier. Back-to-back pairs are accepted on every cycle.
- R8: While `rst` is high at a clock edge, the block clears `out_valid`, `product`, `ovf` and `unf` to 0.
- R9: In any cycle where `out_valid` is 0, `product`, `ovf` and `unf` are all 0. `ovf` and `unf` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair valid |
| op_a | input | 32 | First operand, single precision |
| op_b | input | 32 | Second operand, single precision |
| out_valid | output | 1 | Product valid, two cycles after in_valid |
| product | output | 32 | Single-precision product |
| ovf | output | 1 | Result exponent overflowed; product is signed infinity |
| unf | output | 1 | Result exponent underflowed; product is signed zero |

## Verification
The assertions check the following on every cycle:
- the two-cycle valid timing;
- the sign XOR;
- the exact encodings forced on overflow and underflow;
- the zero outputs and exclusive flags when no result is valid.

Only the bench's sweeps can show the following:
- correct exponent arithmetic and the choice between the two normalization paths;
- truncation of the discarded significand bits;
- the exact boundary exponents where overflow and underflow begin, including cases where the one-bit normalization shift pushes a result across a limit.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

    localparam int FP_EXP_W  = 8;
    localparam int FP_FRAC_W = 23;
    localparam int FP_BIAS   = 127;

    localparam int FP_W     = 1 + FP_EXP_W + FP_FRAC_W;
    localparam int SIG_W    = FP_FRAC_W + 1;
    localparam int PROD_W   = 2 * SIG_W;
    localparam int EXPI_W   = FP_EXP_W + 2;
    localparam int EXP_MAX  = (1 << FP_EXP_W) - 1;

    typedef struct packed {
        logic                 sign;
        logic [FP_EXP_W-1:0]  exp;
        logic [FP_FRAC_W-1:0] frac;
    } fp_word_t;

    typedef struct packed {
        logic                     valid;
        logic                     sign;
        logic signed [EXPI_W-1:0] exp;
        logic [PROD_W-1:0]        prod;
    } mul_stage_t;

    function automatic fp_word_t split_word(input logic [FP_W-1:0] w);
        fp_word_t f;
        f.sign = w[FP_W-1];
        f.exp  = w[FP_W-2 -: FP_EXP_W];
        f.frac = w[FP_FRAC_W-1:0];
        return f;
    endfunction

    function automatic logic [SIG_W-1:0] with_hidden(input fp_word_t f);
        return {1'b1, f.frac};
    endfunction

endpackage

// File: rtl/fmul_unpack.sv
module fmul_unpack
    import fmul_pkg::*;
(
    input  logic [FP_W-1:0] word,
    output fp_word_t        fields
);
    always_comb fields = split_word(word);
endmodule

// File: rtl/fmul_core.sv
module fmul_core
    import fmul_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  fp_word_t   fa,
    input  fp_word_t   fb,
    output mul_stage_t st
);
    logic signed [EXPI_W-1:0] exp_sum;
    logic [PROD_W-1:0]        sig_prod;

    always_comb begin
        exp_sum = signed'(EXPI_W'(fa.exp)) + signed'(EXPI_W'(fb.exp))
                - signed'(EXPI_W'(FP_BIAS));
        sig_prod = PROD_W'(with_hidden(fa)) * PROD_W'(with_hidden(fb));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.valid <= in_valid;
            st.sign  <= fa.sign ^ fb.sign;
            st.exp   <= exp_sum;
            st.prod  <= sig_prod;
        end
    end
endmodule

// File: rtl/fmul_norm.sv
module fmul_norm
    import fmul_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  mul_stage_t      st,
    output logic            out_valid,
    output logic [FP_W-1:0] product,
    output logic            ovf,
    output logic            unf
);
    logic                     carry;
    logic signed [EXPI_W-1:0] exp_fin;
    logic [FP_FRAC_W-1:0]     frac_kept;
    logic                     too_big;
    logic                     too_small;
    fp_word_t                 packed_res;

    always_comb begin
        carry     = st.prod[PROD_W-1];
        exp_fin   = st.exp + signed'(EXPI_W'(carry));
        frac_kept = carry ? st.prod[PROD_W-2 -: FP_FRAC_W]
                          : st.prod[PROD_W-3 -: FP_FRAC_W];
        too_big   = exp_fin >= signed'(EXPI_W'(EXP_MAX));
        too_small = exp_fin <= signed'(EXPI_W'(0));
        packed_res.sign = st.sign;
        if (too_big) begin
            packed_res.exp  = '1;
            packed_res.frac = '0;
        end else if (too_small) begin
            packed_res.exp  = '0;
            packed_res.frac = '0;
        end else begin
            packed_res.exp  = exp_fin[FP_EXP_W-1:0];
            packed_res.frac = frac_kept;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !st.valid) begin
            out_valid <= 1'b0;
            product   <= '0;
            ovf       <= 1'b0;
            unf       <= 1'b0;
        end else begin
            out_valid <= 1'b1;
            product   <= packed_res;
            ovf       <= too_big;
            unf       <= too_small && !too_big;
        end
    end
endmodule

// File: rtl/fmul_sp.sv
module fmul_sp
    import fmul_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    output logic        out_valid,
    output logic [31:0] product,
    output logic        ovf,
    output logic        unf
);
    fp_word_t   fld [2];
    mul_stage_t st1;

    for (genvar gi = 0; gi < 2; gi++) begin : g_unpack
        fmul_unpack u_unp (
            .word   (gi == 0 ? op_a : op_b),
            .fields (fld[gi])
        );
    end

    fmul_core u_core (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .fa       (fld[0]),
        .fb       (fld[1]),
        .st       (st1)
    );

    fmul_norm u_norm (
        .clk       (clk),
        .rst       (rst),
        .st        (st1),
        .out_valid (out_valid),
        .product   (product),
        .ovf       (ovf),
        .unf       (unf)
    );
endmodule

// File: rtl/fmul_sp_chk.sv
module fmul_sp_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic        out_valid,
    input logic [31:0] product,
    input logic        ovf,
    input logic        unf
);
    a_r1_sign_xor: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 (product[31] == $past(op_a[31] ^ op_b[31], 2)));

    a_r5_inf_on_ovf: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (product[30:23] == 8'hFF && product[22:0] == 23'd0));

    a_r6_zero_on_unf: assert property (@(posedge clk) disable iff (rst)
        unf |-> (product[30:0] == 31'd0));

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    a_r7_gap_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (product == 32'd0 && !ovf && !unf));

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ovf && unf));
endmodule

bind fmul_sp fmul_sp_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product),
    .ovf       (ovf),
    .unf       (unf)
);

// File: tb/sim_fmul_sp.sv
module sim_fmul_sp;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [31:0] product;
    logic        ovf;
    logic        unf;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] e_p [2];
    logic        e_v [2];
    logic        e_o [2];
    logic        e_u [2];
    int          e_c [2];

    always #10 clk = ~clk;

    fmul_sp u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .product(product), .ovf(ovf), .unf(unf)
    );

    // cat: 2 = R2 path, 3 = R3 path, 4 = R4 truncation, 5 = R5, 6 = R6
    function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] p, output logic ov,
                                  output logic un, output int cat);
        longint ma, mb, pr;
        int e;
        logic [22:0] fr;
        logic s;
        s  = a[31] ^ b[31];
        ma = longint'({1'b1, a[22:0]});
        mb = longint'({1'b1, b[22:0]});
        pr = ma * mb;
        e  = int'(a[30:23]) + int'(b[30:23]) - 127;
        if (pr >= (longint'(1) << 47)) begin
            e++;
            fr  = 23'((pr >> 24) & longint'(23'h7FFFFF));
            cat = 3;
        end else begin
            fr  = 23'((pr >> 23) & longint'(23'h7FFFFF));
            cat = 2;
        end
        if (a[22:0] == 23'h7FFFFF && b[22:0] == 23'h7FFFFF) cat = 4;
        ov = 1'b0;
        un = 1'b0;
        if (e >= 255) begin
            ov = 1'b1; p = {s, 8'hFF, 23'd0}; cat = 5;
        end else if (e <= 0) begin
            un = 1'b1; p = {s, 31'd0}; cat = 6;
        end else begin
            p = {s, 8'(e), fr};
        end
    endfunction

    task automatic fail_line(input string req, input logic [34:0] act, input logic [34:0] exp);
        errors++;
        $display("FAIL %s actual=%h expected=%h", req, act, exp);
    endtask

    task automatic check_outputs();
        checks++;
        if (out_valid !== e_v[1]) fail_line("R7", 35'(out_valid), 35'(e_v[1]));
        if (e_v[1]) begin
            checks++;
            if (product[31] !== e_p[1][31]) fail_line("R1", 35'(product[31]), 35'(e_p[1][31]));
            checks++;
            if ({product, ovf, unf} !== {e_p[1], e_o[1], e_u[1]}) begin
                case (e_c[1])
                    2: fail_line("R2", {1'b0, product, ovf, unf}, {1'b0, e_p[1], e_o[1], e_u[1]});
                    3: fail_line("R3", {1'b0, product, ovf, unf}, {1'b0, e_p[1], e_o[1], e_u[1]});
                    4: fail_line("R4", {1'b0, product, ovf, unf}, {1'b0, e_p[1], e_o[1], e_u[1]});
                    5: fail_line("R5", {1'b0, product, ovf, unf}, {1'b0, e_p[1], e_o[1], e_u[1]});
                    default: fail_line("R6", {1'b0, product, ovf, unf}, {1'b0, e_p[1], e_o[1], e_u[1]});
                endcase
            end
        end else begin
            checks++;
            if ({product, ovf, unf} !== 34'd0) fail_line("R9", {1'b0, product, ovf, unf}, 35'd0);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] p;
        logic ov, un;
        int cat;
        @(negedge clk);
        check_outputs();
        e_p[1] = e_p[0]; e_v[1] = e_v[0]; e_o[1] = e_o[0]; e_u[1] = e_u[0]; e_c[1] = e_c[0];
        model(a, b, p, ov, un, cat);
        in_valid = v; op_a = a; op_b = b;
        e_v[0] = v; e_p[0] = p; e_o[0] = ov; e_u[0] = un; e_c[0] = cat;
    endtask

    initial begin
        automatic int exps [12] = '{1, 2, 63, 64, 100, 126, 127, 128, 190, 200, 253, 254};
        automatic logic [22:0] fracs [5] = '{23'h000000, 23'h7FFFFF, 23'h400000, 23'h2AAAAA, 23'h123456};
        automatic int idx = 0;
        for (int k = 0; k < 2; k++) begin
            e_v[k] = 1'b0; e_p[k] = '0; e_o[k] = 1'b0; e_u[k] = 1'b0; e_c[k] = 2;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({out_valid, product, ovf, unf} !== 35'd0)
            fail_line("R8", {out_valid, product, ovf, unf}, 35'd0);
        rst = 1'b0;
        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 12; j++) begin
                for (int fa = 0; fa < 5; fa++) begin
                    for (int fb = 0; fb < 5; fb++) begin
                        if (idx % 7 == 6) step(1'b0, 32'd0, 32'd0);
                        step(1'b1,
                             {idx[0], 8'(exps[i]), fracs[fa]},
                             {idx[1] ^ idx[3], 8'(exps[j]), fracs[fb]});
                        idx++;
                    end
                end
            end
        end
        step(1'b0, 32'd0, 32'd0);
        step(1'b0, 32'd0, 32'd0);
        step(1'b0, 32'd0, 32'd0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule